// File: doc/BRIEF.md
# Per-Core Locality Classifier for One Directory Line

This block keeps the reuse-based placement state that a directory holds for one cache line. For each core it records a mode bit and a small utilization counter. The mode bit says whether the core gets a full private copy of the line or is served one word at a time at the shared cache. Requests arrive one per cycle. Each carries a core ID and is a read, a write, or a report that a private copy was dropped, together with the count of hits that copy saw. For every accepted request the block returns a grant code on the next cycle and updates the state of the cores involved.

A core that dropped its private copy after too little use is moved to word-access mode. While it stays there, each of its accesses is counted. Once the count shows enough reuse, the core is given the whole line again. A write by any core clears the counts of the other word-mode cores, because their earlier reuse is no longer valid. The threshold comes from an input pin. It is captured only on idle cycles, so a stream of requests always sees one threshold value.

Top module: `lac_classifier`

## Requirements
- R1: After reset, every core is in private mode (all `modeView` bits 0) and every counter in `utilView` is 0. `rspValid` is low and `reqReady` is high.
- R2: A request is accepted on a rising edge where `reqValid` and `reqReady` are both high. Each accepted request produces exactly one cycle of `rspValid` on the following cycle, and `rspCore` echoes the requesting core. With no accepted request, the mode and counter state does not change.
- R3: A read (`reqOp`=0) or write (`reqOp`=1) from a core in private mode gets the line grant (`rspGrant`=2), and that core's mode and counter stay the same.
- R4: A read or write from a core in remote mode (`modeView` bit = 1) whose counter, after a saturating increment, is still below the threshold gets the word grant (`rspGrant`=1). The core's counter takes the incremented value.
- R5: A read or write from a remote-mode core whose incremented counter reaches or passes the threshold gets the line grant. That core returns to private mode and its counter is cleared.
- R6: A write from any core clears the counter of every other core that is in remote mode.
- R7: A report (`reqOp`=2) from a private-mode core whose `reqUtil` is below the threshold moves that core to remote mode with its counter at 0. A report whose `reqUtil` is at or above the threshold leaves the core private. A report always gets the empty grant (`rspGrant`=0).
- R8: A report from a core that is already in remote mode changes no mode bit and no counter.
- R9: The threshold is loaded from `pctIn` only at rising edges where `reqValid` is low. A change of `pctIn` during a back-to-back run of requests takes effect only after the next idle cycle. Core i's counter is at `utilView[i*CNT_W +: CNT_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can take a request |
| reqCore | input | CORE_W | Requesting core ID |
| reqOp | input | 2 | 0 read, 1 write, 2 report of a dropped private copy |
| reqUtil | input | CNT_W | Private hit count carried by a report |
| pctIn | input | PCT_W | Threshold, captured on idle cycles |
| rspValid | output | 1 | Grant valid, one cycle after acceptance |
| rspGrant | output | 2 | 0 none, 1 single word, 2 full line |
| rspCore | output | CORE_W | Core the grant belongs to |
| modeView | output | NUM_CORES | Bit i set when core i is in remote mode |
| utilView | output | NUM_CORES*CNT_W | Per-core remote utilization counters |

## Verification
The assertions assume `reqCore` always names an existing core and `reqOp` never carries the unused code 3. They also assume that while `rstN` is low no request is accepted. The stimulus drives only valid core indices and the three defined operations, and it holds `reqValid` low throughout reset. The threshold is changed only in the middle of a back-to-back stream or during idle gaps, which are the two cases the capture rule separates.

// File: rtl/lac_pkg.sv
package lac_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_REPORT = 2'd2,
    OP_RSVD   = 2'd3
  } opE;

  typedef enum logic [1:0] {
    GR_NONE = 2'd0,
    GR_WORD = 2'd1,
    GR_LINE = 2'd2
  } grantE;

  // strobes from control to datapath for the request being accepted
  typedef struct packed {
    logic access;   // read or write
    logic isWrite;  // write only
    logic report;   // dropped private copy
  } strobeT;

endpackage

// File: rtl/lac_ctrl.sv
module lac_ctrl
  import lac_pkg::*;
#(
  parameter int CORE_W  = 2,
  parameter int PCT_W   = 3,
  parameter int DEF_PCT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [PCT_W-1:0]  pctIn,
  input  grantE             grantNext,
  output logic              reqReady,
  output strobeT            strobe,
  output logic [PCT_W-1:0]  pctQ,
  output logic              rspValid,
  output grantE             rspGrant,
  output logic [CORE_W-1:0] rspCore
);

  logic readyQ;
  logic accept;

  assign reqReady = readyQ;
  assign accept   = reqValid && readyQ;

  always_comb begin
    strobe         = '0;
    strobe.access  = accept && (reqOp == OP_READ || reqOp == OP_WRITE);
    strobe.isWrite = accept && (reqOp == OP_WRITE);
    strobe.report  = accept && (reqOp == OP_REPORT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= 1'b0;
    end else begin
      readyQ <= 1'b1;
    end
  end

  // threshold is only refreshed while the request path is idle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pctQ <= PCT_W'(DEF_PCT);
    end else if (!reqValid) begin
      pctQ <= pctIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspGrant <= GR_NONE;
      rspCore  <= '0;
    end else begin
      rspValid <= accept;
      if (accept) begin
        rspGrant <= grantNext;
        rspCore  <= reqCore;
      end
    end
  end

endmodule

// File: rtl/lac_datapath.sv
module lac_datapath
  import lac_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2,
  parameter int CNT_W     = 3,
  parameter int PCT_W     = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobeT                     strobe,
  input  logic [CORE_W-1:0]          reqCore,
  input  logic [CNT_W-1:0]           reqUtil,
  input  logic [PCT_W-1:0]           pctQ,
  output grantE                      grantNext,
  output logic [NUM_CORES-1:0]       modeView,
  output logic [NUM_CORES*CNT_W-1:0] utilView
);

  localparam int CMP_W = (CNT_W > PCT_W) ? CNT_W : PCT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_CORES-1:0] modeQ;
  logic [NUM_CORES-1:0] promote;
  logic [NUM_CORES-1:0] selHit;
  logic [CMP_W-1:0]     pctWide;
  logic [CMP_W-1:0]     utilWide;

  assign pctWide  = CMP_W'(pctQ);
  assign utilWide = CMP_W'(reqUtil);

  generate
    for (genvar gi = 0; gi < NUM_CORES; gi++) begin : gCore
      logic [CNT_W-1:0] cntQ;
      logic [CNT_W-1:0] cntInc;
      logic             isSel;

      assign isSel       = (reqCore == CORE_W'(gi));
      assign selHit[gi]  = isSel;
      assign cntInc      = (cntQ == CNT_MAX) ? cntQ : cntQ + 1'b1;
      assign promote[gi] = modeQ[gi] && (CMP_W'(cntInc) >= pctWide);
      assign utilView[gi*CNT_W +: CNT_W] = cntQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          modeQ[gi] <= 1'b0;
          cntQ      <= '0;
        end else if (strobe.access && isSel) begin
          if (modeQ[gi]) begin
            if (promote[gi]) begin
              modeQ[gi] <= 1'b0;
              cntQ      <= '0;
            end else begin
              cntQ <= cntInc;
            end
          end
        end else if (strobe.isWrite && !isSel) begin
          // another core wrote: earlier word reuse no longer counts
          if (modeQ[gi]) begin
            cntQ <= '0;
          end
        end else if (strobe.report && isSel) begin
          if (!modeQ[gi] && (utilWide < pctWide)) begin
            modeQ[gi] <= 1'b1;
            cntQ      <= '0;
          end
        end
      end
    end
  endgenerate

  assign modeView = modeQ;

  logic selRemote;
  logic selPromote;

  always_comb begin
    selRemote  = 1'b0;
    selPromote = 1'b0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (selHit[i]) begin
        selRemote  = modeQ[i];
        selPromote = promote[i];
      end
    end
  end

  always_comb begin
    if (!strobe.access) begin
      grantNext = GR_NONE;
    end else if (selRemote && !selPromote) begin
      grantNext = GR_WORD;
    end else begin
      grantNext = GR_LINE;
    end
  end

endmodule

// File: rtl/lac_classifier.sv
module lac_classifier
  import lac_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 3,
  parameter int PCT_W     = 3,
  parameter int DEF_PCT   = 4,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic [CORE_W-1:0]          reqCore,
  input  logic [1:0]                 reqOp,
  input  logic [CNT_W-1:0]           reqUtil,
  input  logic [PCT_W-1:0]           pctIn,
  output logic                       rspValid,
  output logic [1:0]                 rspGrant,
  output logic [CORE_W-1:0]          rspCore,
  output logic [NUM_CORES-1:0]       modeView,
  output logic [NUM_CORES*CNT_W-1:0] utilView
);

  strobeT           strobe;
  grantE            grantNext;
  grantE            rspGrantE;
  logic [PCT_W-1:0] pctQ;

  lac_ctrl #(
    .CORE_W (CORE_W),
    .PCT_W  (PCT_W),
    .DEF_PCT(DEF_PCT)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqCore  (reqCore),
    .pctIn    (pctIn),
    .grantNext(grantNext),
    .reqReady (reqReady),
    .strobe   (strobe),
    .pctQ     (pctQ),
    .rspValid (rspValid),
    .rspGrant (rspGrantE),
    .rspCore  (rspCore)
  );

  lac_datapath #(
    .NUM_CORES(NUM_CORES),
    .CORE_W   (CORE_W),
    .CNT_W    (CNT_W),
    .PCT_W    (PCT_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqCore  (reqCore),
    .reqUtil  (reqUtil),
    .pctQ     (pctQ),
    .grantNext(grantNext),
    .modeView (modeView),
    .utilView (utilView)
  );

  assign rspGrant = rspGrantE;

endmodule

// File: rtl/lac_checker.sv
module lac_checker #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2,
  parameter int CNT_W     = 3
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       reqValid,
  input logic                       reqReady,
  input logic [CORE_W-1:0]          reqCore,
  input logic [1:0]                 reqOp,
  input logic                       rspValid,
  input logic [1:0]                 rspGrant,
  input logic [CORE_W-1:0]          rspCore,
  input logic [NUM_CORES-1:0]       modeView,
  input logic [NUM_CORES*CNT_W-1:0] utilView
);

  logic accept;
  assign accept = reqValid && reqReady;

  // R2
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> rspValid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !rspValid);

  // R2
  rsp_core_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> (rspCore == $past(reqCore)));

  // R2
  idle_state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> ($stable(modeView) && $stable(utilView)));

  // R3
  private_gets_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && (reqOp == 2'd0 || reqOp == 2'd1) && !modeView[reqCore])
      |=> (rspGrant == 2'd2));

  // R7
  report_no_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqOp == 2'd2) |=> (rspGrant == 2'd0));

  // R8
  remote_report_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqOp == 2'd2 && modeView[reqCore])
      |=> ($stable(modeView) && $stable(utilView)));

endmodule

bind lac_classifier lac_checker #(
  .NUM_CORES(NUM_CORES),
  .CORE_W   (CORE_W),
  .CNT_W    (CNT_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqCore (reqCore),
  .reqOp   (reqOp),
  .rspValid(rspValid),
  .rspGrant(rspGrant),
  .rspCore (rspCore),
  .modeView(modeView),
  .utilView(utilView)
);

// File: tb/sim_lac_classifier.sv
module sim_lac_classifier;

  localparam int N  = 4;
  localparam int CW = 3;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [1:0]    reqCore = '0;
  logic [1:0]    reqOp = '0;
  logic [CW-1:0] reqUtil = '0;
  logic [PW-1:0] pctIn = 3'd2;
  logic          rspValid;
  logic [1:0]    rspGrant;
  logic [1:0]    rspCore;
  logic [N-1:0]  modeView;
  logic [N*CW-1:0] utilView;

  always #5 clk = ~clk;

  lac_classifier #(.NUM_CORES(N), .CNT_W(CW), .PCT_W(PW), .DEF_PCT(4)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqCore(reqCore), .reqOp(reqOp), .reqUtil(reqUtil), .pctIn(pctIn),
    .rspValid(rspValid), .rspGrant(rspGrant), .rspCore(rspCore),
    .modeView(modeView), .utilView(utilView)
  );

  typedef struct {
    logic [1:0]      core;
    logic [1:0]      grant;
    logic [N-1:0]    mode;
    logic [N*CW-1:0] util;
    string           tag;
  } expT;

  expT expQ[$];
  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 0;

  // bench reference state, built from the requirements
  bit tbMode[N];
  int tbCnt[N];
  int tbPct = 2;

  always @(posedge clk) if (!reqValid) tbPct <= int'(pctIn);

  task automatic check(string tag, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input int c, input int op, input int u, output logic [1:0] g);
    if (op == 2) begin
      if (!tbMode[c] && u < tbPct) begin
        tbMode[c] = 1;
        tbCnt[c]  = 0;
      end
      g = 2'd0;
    end else begin
      if (!tbMode[c]) begin
        g = 2'd2;
      end else begin
        int n;
        n = (tbCnt[c] == 7) ? 7 : tbCnt[c] + 1;
        if (n >= tbPct) begin
          tbMode[c] = 0;
          tbCnt[c]  = 0;
          g = 2'd2;
        end else begin
          tbCnt[c] = n;
          g = 2'd1;
        end
      end
      if (op == 1) begin
        for (int j = 0; j < N; j++) if (j != c && tbMode[j]) tbCnt[j] = 0;
      end
    end
  endtask

  task automatic send(input int c, input int op, input int u, input string tag);
    expT e;
    logic [1:0] g;
    @(negedge clk);
    reqValid = 1'b1;
    reqCore  = 2'(c);
    reqOp    = 2'(op);
    reqUtil  = CW'(u);
    model(c, op, u, g);
    e.core  = 2'(c);
    e.grant = g;
    for (int i = 0; i < N; i++) begin
      e.mode[i] = tbMode[i];
      e.util[i*CW +: CW] = CW'(tbCnt[i]);
    end
    e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check("R2", "unexpected response", 1, 0);
      end else begin
        expT e;
        e = expQ.pop_front();
        check(e.tag, "grant", rspGrant, e.grant);
        check("R2", "core", rspCore, e.core);
        check(e.tag, "mode", modeView, e.mode);
        check(e.tag, "util", utilView, e.util);
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < N; i++) begin tbMode[i] = 0; tbCnt[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "modeView", modeView, 0);
    check("R1", "utilView", utilView, 0);
    check("R1", "rspValid", rspValid, 0);
    check("R1", "reqReady", reqReady, 1);
    idle(2);

    send(0, 0, 0, "R3");     // private read -> line
    send(0, 2, 1, "R7");     // 1 < 2 -> remote
    send(0, 0, 0, "R4");     // word, count 1
    send(1, 1, 0, "R6");     // other core writes -> core0 count 0
    send(0, 0, 0, "R4");     // word, count 1
    send(0, 1, 0, "R5");     // count reaches 2 -> line, private
    send(2, 2, 2, "R7");     // at threshold: stays private
    send(2, 2, 1, "R7");     // below: remote
    send(2, 2, 0, "R8");     // already remote: ignored
    send(2, 0, 0, "R4");     // core2 count 1
    send(0, 2, 0, "R7");     // core0 remote
    send(0, 1, 0, "R6");     // core0 word, core2 count cleared
    pctIn = 3'd5;            // changed mid-stream
    send(3, 2, 3, "R9");     // old threshold 2 still used: stays private
    send(3, 2, 4, "R9");
    idle(1);                 // new threshold captured here
    send(3, 2, 4, "R9");     // 4 < 5 -> remote
    send(3, 0, 0, "R4");
    send(3, 1, 0, "R4");
    send(3, 0, 0, "R4");
    send(3, 0, 0, "R4");     // count 4
    send(3, 0, 0, "R5");     // reaches 5 -> line
    send(1, 0, 0, "R3");
    idle(4);
    // R2 every accepted request answered
    check("R2", "pending responses", expQ.size(), 0);
    summary();
  end

endmodule